// File: doc/BRIEF.md
# Register List Transfer Sequencer

This block runs the memory side of a block transfer instruction. It is given an 8-bit register list, a base address, an operation and a start strobe. It then issues one 32-bit word request per accepted transfer over a valid/ready handshake. Four operations are supported: increment-after load, increment-after store, stack push and stack pop. Push can also save the link register, and pop can also restore the program counter.

For stores, the register file outside the block supplies the data, selected by the request's register index. For loads, the block hands the word back together with its destination index in the cycle the request is accepted. At completion it pulses done and reports three things: the new base value, whether the base should be written, and how many words moved.

Top module: `reglist_xfer_seq`

## Requirements
- R1: Every selected register costs exactly one accepted word request, and consecutive requests of one operation differ in address by exactly 4.
- R2: For load (op 0), store (op 1) and pop (op 3), list registers are requested in ascending index order, the first at the base address, each next one 4 higher.
- R3: For push (op 2), the first request is at base minus 4, and list registers follow in descending index order, each 4 lower than the previous request.
- R4: A push with the extra flag set writes the link register (index 14) first, at base minus 4, before any list register.
- R5: After a push, the reported base value is the lowest address written, or the base itself when nothing was written.
- R6: A pop with the extra flag set reads the program counter (index 15) last, one word above the last list word, and returns it with bit 0 forced to 0.
- R7: After a pop, the reported base value is one word above the last word read.
- R8: Load reports base write enable only when the list bit at the base index is 0; store, push and pop always report it set. The reported value for load and store is one word past the last transfer.
- R9: The count output at done equals the number of words transferred.
- R10: An empty list with no extra transfer raises done in the cycle after start, issues no request, and reports the start base as the new base.
- R11: While a request is valid and ready is low, the request stays valid with unchanged address and register index.
- R12: Each accepted load (ops 0 and 3) presents the read word and its register index on the load outputs in that same cycle; stores (ops 1 and 2) assert the write flag and produce no load output.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| op_i | input | 2 | 0 load, 1 store, 2 push, 3 pop |
| mask_i | input | 8 | Register list, bit i selects register i |
| extra_i | input | 1 | Push: also save link register; pop: also load program counter |
| base_idx_i | input | 3 | Index of the base register (load writeback rule) |
| base_i | input | 32 | Base address or stack pointer |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_write_o | output | 1 | 1 for a word write, 0 for a word read |
| req_addr_o | output | 32 | Word address of the request |
| req_reg_o | output | 4 | Register index of the request (14 link, 15 program counter) |
| mem_rdata_i | input | 32 | Read word, valid in the accepting cycle |
| ld_valid_o | output | 1 | Load word returned this cycle |
| ld_idx_o | output | 4 | Destination register of the load |
| ld_data_o | output | 32 | Loaded word |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base register should be updated (with done) |
| wb_value_o | output | 32 | New base value (with done) |
| count_o | output | 4 | Words transferred (with done) |

## Verification
The corners that are hardest to reach are the extra transfers at the ends of the sequence. The link register slot must come before the highest list register on a push, and the program counter slot must follow after the list is exhausted on a pop. The bench drives pushes and pops with sparse, full and empty lists, both with and without the extra flag, so both ends are exercised, including the case where the extra word is the only transfer. A ready pattern that drops two cycles in three is applied on several vectors, so every stalled request is seen held.

// File: rtl/rls_pkg.sv
package rls_pkg;
  localparam int RLS_AW = 32;
  localparam int RLS_STEP = 4;

  typedef enum logic [1:0] {
    OP_LDIA = 2'd0,
    OP_STIA = 2'd1,
    OP_PUSH = 2'd2,
    OP_POP  = 2'd3
  } rls_op_e;

  // address of the first transfer for an operation
  function automatic logic [RLS_AW-1:0] first_addr(rls_op_e op, logic [RLS_AW-1:0] base);
    return (op == OP_PUSH) ? base - RLS_AW'(RLS_STEP) : base;
  endfunction

  // address after one transfer
  function automatic logic [RLS_AW-1:0] next_addr(logic down, logic [RLS_AW-1:0] a);
    return down ? a - RLS_AW'(RLS_STEP) : a + RLS_AW'(RLS_STEP);
  endfunction

  // new base value from the address pointer at completion
  function automatic logic [RLS_AW-1:0] final_base(rls_op_e op, logic [RLS_AW-1:0] a);
    return (op == OP_PUSH) ? a + RLS_AW'(RLS_STEP) : a;
  endfunction
endpackage

// File: rtl/rls_pick.sv
module rls_pick #(
  parameter int NREG       = 8,
  parameter bit HIGH_FIRST = 1'b0,
  localparam int IW        = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic            any,
  output logic [IW-1:0]   idx
);
  assign any = |mask;

  generate
    if (HIGH_FIRST) begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < NREG; i++)
          if (mask[i]) idx = IW'(i);
      end
    end else begin : g_low
      always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--)
          if (mask[i]) idx = IW'(i);
      end
    end
  endgenerate
endmodule

// File: rtl/rls_addr.sv
module rls_addr
  import rls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RLS_AW-1:0] load_val,
  input  logic              step,
  input  logic              down,
  output logic [RLS_AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= next_addr(down, addr);
  end
endmodule

// File: rtl/reglist_xfer_seq.sv
module reglist_xfer_seq
  import rls_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int REG_IW = 4,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15,
  localparam int PW    = $clog2(NREG),
  localparam int CW    = $clog2(NREG + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic              extra_i,
  input  logic [PW-1:0]     base_idx_i,
  input  logic [RLS_AW-1:0] base_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [RLS_AW-1:0] req_addr_o,
  output logic [REG_IW-1:0] req_reg_o,
  input  logic [RLS_AW-1:0] mem_rdata_i,
  output logic              ld_valid_o,
  output logic [REG_IW-1:0] ld_idx_o,
  output logic [RLS_AW-1:0] ld_data_o,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [RLS_AW-1:0] wb_value_o,
  output logic [CW-1:0]     count_o
);
  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e            state_q;
  rls_op_e           op_q;
  logic [NREG-1:0]   mask_q;
  logic              extra_q;
  logic              inlist_q;
  logic [CW-1:0]     cnt_q;

  logic              lo_any, hi_any;
  logic [PW-1:0]     lo_idx, hi_idx;
  logic              running, have_item, item_extra, accept, launch;
  logic              is_push;
  logic [REG_IW-1:0] cur_idx;
  logic [RLS_AW-1:0] addr_q;

  rls_pick #(.NREG(NREG), .HIGH_FIRST(1'b0)) u_pick_lo (
    .mask(mask_q), .any(lo_any), .idx(lo_idx));
  rls_pick #(.NREG(NREG), .HIGH_FIRST(1'b1)) u_pick_hi (
    .mask(mask_q), .any(hi_any), .idx(hi_idx));

  assign running = (state_q == S_RUN);
  assign is_push = (op_q == OP_PUSH);
  assign launch  = (state_q == S_IDLE) && start_i;

  // choose the current transfer: link first on push, program counter last on pop
  always_comb begin
    cur_idx    = '0;
    have_item  = 1'b0;
    item_extra = 1'b0;
    if (is_push) begin
      if (extra_q) begin
        cur_idx = REG_IW'(LR_IDX); have_item = 1'b1; item_extra = 1'b1;
      end else if (hi_any) begin
        cur_idx = REG_IW'(hi_idx); have_item = 1'b1;
      end
    end else begin
      if (lo_any) begin
        cur_idx = REG_IW'(lo_idx); have_item = 1'b1;
      end else if (op_q == OP_POP && extra_q) begin
        cur_idx = REG_IW'(PC_IDX); have_item = 1'b1; item_extra = 1'b1;
      end
    end
  end

  assign req_valid_o = running && have_item;
  assign accept      = req_valid_o && req_ready_i;
  assign req_write_o = (op_q == OP_STIA) || is_push;
  assign req_reg_o   = cur_idx;
  assign req_addr_o  = addr_q;

  rls_addr u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(launch), .load_val(first_addr(rls_op_e'(op_i), base_i)),
    .step(accept), .down(is_push),
    .addr(addr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OP_LDIA;
      mask_q   <= '0;
      extra_q  <= 1'b0;
      inlist_q <= 1'b0;
      cnt_q    <= '0;
    end else if (launch) begin
      state_q  <= S_RUN;
      op_q     <= rls_op_e'(op_i);
      mask_q   <= mask_i;
      extra_q  <= extra_i;
      inlist_q <= mask_i[base_idx_i];
      cnt_q    <= '0;
    end else if (running) begin
      if (!have_item) state_q <= S_IDLE;
      if (accept) begin
        cnt_q <= cnt_q + 1'b1;
        if (item_extra) extra_q <= 1'b0;
        else            mask_q[cur_idx[PW-1:0]] <= 1'b0;
      end
    end
  end

  assign ld_valid_o = accept && !req_write_o;
  assign ld_idx_o   = cur_idx;
  assign ld_data_o  = (cur_idx == REG_IW'(PC_IDX)) ? {mem_rdata_i[RLS_AW-1:1], 1'b0} : mem_rdata_i;

  assign done_o     = running && !have_item;
  assign wb_en_o    = done_o && !(op_q == OP_LDIA && inlist_q);
  assign wb_value_o = final_base(op_q, addr_q);
  assign count_o    = cnt_q;
endmodule

// File: rtl/rls_chk.sv
module rls_chk #(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [IW-1:0] req_reg,
  input logic          ld_valid,
  input logic [IW-1:0] ld_idx,
  input logic [AW-1:0] ld_data,
  input logic          done,
  input logic [1:0]    op
);
  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_reg));

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready) && req_valid |->
      req_addr == ((op == 2'd2) ? $past(req_addr) - AW'(4) : $past(req_addr) + AW'(4)));

  // R6
  pc_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_idx == IW'(15) |-> !ld_data[0]);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !req_valid);

  // R12
  store_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (op == 2'd1 || op == 2'd2) |-> req_write && !ld_valid);
endmodule

bind reglist_xfer_seq rls_chk #(.AW(rls_pkg::RLS_AW), .IW(REG_IW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid_o), .req_ready(req_ready_i), .req_write(req_write_o),
  .req_addr(req_addr_o), .req_reg(req_reg_o),
  .ld_valid(ld_valid_o), .ld_idx(ld_idx_o), .ld_data(ld_data_o),
  .done(done_o), .op(op_q));

// File: tb/reglist_xfer_seq_tb.sv
module reglist_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [7:0]  mask_i = '0;
  logic        extra_i = 1'b0;
  logic [2:0]  base_idx_i = '0;
  logic [31:0] base_i = '0;
  logic        req_valid_o, req_write_o, ld_valid_o, done_o, wb_en_o;
  logic        req_ready_i = 1'b1;
  logic [31:0] req_addr_o, mem_rdata_i, ld_data_o, wb_value_o;
  logic [3:0]  req_reg_o, ld_idx_o, count_o;

  int n_tests = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;
  assign mem_rdata_i = ~req_addr_o;

  reglist_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .mask_i(mask_i),
    .extra_i(extra_i), .base_idx_i(base_idx_i), .base_i(base_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_write_o(req_write_o),
    .req_addr_o(req_addr_o), .req_reg_o(req_reg_o), .mem_rdata_i(mem_rdata_i),
    .ld_valid_o(ld_valid_o), .ld_idx_o(ld_idx_o), .ld_data_o(ld_data_o),
    .done_o(done_o), .wb_en_o(wb_en_o), .wb_value_o(wb_value_o), .count_o(count_o));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {op[46:45], extra[44], base_idx[43:41], mask[40:33], base[32:1], stall[0]}
  localparam int NV = 12;
  localparam logic [46:0] VEC [NV] = '{
    {2'd0, 1'b0, 3'd5, 8'h0F, 32'h0000_1000, 1'b0},  // load, base not in list
    {2'd0, 1'b0, 3'd5, 8'h21, 32'h0000_1100, 1'b1},  // load, base in list
    {2'd1, 1'b0, 3'd0, 8'h81, 32'h0000_2000, 1'b1},  // store ends
    {2'd2, 1'b1, 3'd5, 8'h05, 32'h0000_3000, 1'b0},  // push with link
    {2'd2, 1'b0, 3'd5, 8'hFF, 32'h0000_3000, 1'b1},  // push full
    {2'd3, 1'b1, 3'd5, 8'h03, 32'h0000_4000, 1'b0},  // pop with pc
    {2'd3, 1'b1, 3'd5, 8'h00, 32'h0000_4100, 1'b1},  // pop pc only
    {2'd0, 1'b0, 3'd1, 8'h00, 32'h0000_5000, 1'b0},  // empty load
    {2'd2, 1'b0, 3'd5, 8'h00, 32'h0000_5100, 1'b0},  // empty push
    {2'd3, 1'b0, 3'd5, 8'h80, 32'h0000_5200, 1'b1},  // pop single high
    {2'd1, 1'b0, 3'd2, 8'h00, 32'h0000_5300, 1'b0},  // empty store
    {2'd2, 1'b1, 3'd5, 8'h00, 32'h0000_5400, 1'b1}   // push link only
  };

  task automatic run_vec(input logic [46:0] v);
    logic [1:0]  op;
    logic        ex, st;
    logic [2:0]  bi;
    logic [7:0]  mk;
    logic [31:0] b, a, ew;
    logic [31:0] e_addr [10];
    logic [3:0]  e_reg [10];
    int n, k, cyc;
    bit  ewb, ewr, stalled;
    logic [31:0] st_addr;
    string tg;
    op = v[46:45]; ex = v[44]; bi = v[43:41]; mk = v[40:33]; b = v[32:1]; st = v[0];
    n = 0;
    if (op == 2'd2) begin
      a = b - 32'd4;
      if (ex) begin e_addr[n] = a; e_reg[n] = 4'd14; n++; a -= 32'd4; end
      for (int i = 7; i >= 0; i--)
        if (mk[i]) begin e_addr[n] = a; e_reg[n] = 4'(i); n++; a -= 32'd4; end
      ew = a + 32'd4;
    end else begin
      a = b;
      for (int i = 0; i < 8; i++)
        if (mk[i]) begin e_addr[n] = a; e_reg[n] = 4'(i); n++; a += 32'd4; end
      if (op == 2'd3 && ex) begin e_addr[n] = a; e_reg[n] = 4'd15; n++; a += 32'd4; end
      ew = a;
    end
    ewb = !(op == 2'd0 && mk[bi]);
    ewr = (op == 2'd1 || op == 2'd2);
    tg = (op == 2'd2) ? "R3/R4" : (op == 2'd3 ? "R2/R6" : "R2");

    @(negedge clk);
    op_i = op; extra_i = ex; base_idx_i = bi; mask_i = mk; base_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 0; cyc = 0; stalled = 0; st_addr = '0;
    forever begin
      req_ready_i = st ? (cyc % 3 == 2) : 1'b1;
      #1;
      if (stalled) begin
        // R11 held request
        chk(req_valid_o && req_addr_o == st_addr, "R11 hold", req_addr_o, st_addr);
        stalled = 0;
      end
      if (done_o) break;
      if (req_valid_o) begin
        if (k < n) begin
          chk(req_addr_o == e_addr[k], {tg, " addr"}, req_addr_o, e_addr[k]);
          chk(req_reg_o == e_reg[k], {tg, " reg"}, 32'(req_reg_o), 32'(e_reg[k]));
          chk(req_write_o == ewr, "R12 write flag", 32'(req_write_o), 32'(ewr));
        end else chk(1'b0, "R1 extra request", 32'(k), 32'(n));
        if (req_ready_i) begin
          if (!ewr && k < n) begin
            chk(ld_valid_o && ld_idx_o == e_reg[k], "R12 load index", 32'(ld_idx_o), 32'(e_reg[k]));
            chk(ld_data_o == (e_reg[k] == 4'd15 ? (~e_addr[k] & ~32'd1) : ~e_addr[k]),
                "R12/R6 load data", ld_data_o, ~e_addr[k]);
          end
          k++;
        end else begin
          stalled = 1; st_addr = req_addr_o;
        end
      end
      cyc++;
      if (cyc > 60) begin chk(1'b0, "R1 no done", 32'(k), 32'(n)); break; end
      @(negedge clk);
    end
    chk(k == n, "R1 words transferred", 32'(k), 32'(n));
    chk(count_o == 4'(n), "R9 count", 32'(count_o), 32'(n));
    chk(wb_value_o == ew, (op == 2'd2) ? "R5 push base" : (op == 2'd3 ? "R7 pop base" : "R8 base value"),
        wb_value_o, ew);
    chk(wb_en_o == ewb, "R8 base write enable", 32'(wb_en_o), 32'(ewb));
    if (n == 0)  // R10 one cycle, no request
      chk(cyc == 0, "R10 empty latency", 32'(cyc), 32'd0);
    @(negedge clk);
    req_ready_i = 1'b1;
    chk(!done_o && !req_valid_o, "R10 done single pulse", 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!req_valid_o && !done_o && !ld_valid_o, "R10 reset idle", 32'(req_valid_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!req_valid_o && !done_o, "R10 idle after reset", 32'(done_o), 32'd0);
    for (int v = 0; v < NV; v++) run_vec(VEC[v]);
    // directed: pop with pc, full stall pattern, odd base alignment of data
    run_vec({2'd3, 1'b1, 3'd0, 8'hFF, 32'h0000_6000, 1'b1});
    // directed: store including base register always writes back (R8)
    run_vec({2'd1, 1'b0, 3'd3, 8'h08, 32'h0000_7000, 1'b0});
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule